// File: doc/BRIEF.md
# Local interrupt selector

This block decides which local interrupt a hart should take next, if it should take one at all. Three 16-bit vectors describe the interrupt sources: which are raised, which are individually enabled, and which have been handed down to the supervisor level. The block combines these vectors with the current privilege level and the two global enable bits, one for machine level and one for supervisor level. From the interrupts that survive, it picks the one with the smallest index.

Trap-entry logic reads the result, which is a valid flag and a 4-bit cause number. The selection logic itself is purely combinational. It is followed by one register stage, so every result appears one clock after the inputs that produced it. A synchronous reset clears that stage.

Top module: `intr_arbiter`

## Requirements
- R1: While the synchronous reset `srst` is high at a clock edge, the outputs become `take_vld`=0 and `take_cause`=0 after that edge.
- R2: An interrupt is a candidate only when its bit is set in both `irq_pend` and `irq_enab`. A raised but disabled source is never chosen.
- R3: A source whose `irq_dlg` bit is 0 belongs to machine level. It is eligible when the privilege is not machine (value 3). At machine privilege it is eligible only when `m_gie` is 1.
- R4: A source whose `irq_dlg` bit is 1 belongs to supervisor level. It is eligible below supervisor privilege. At supervisor privilege (value 1) it is eligible only when `s_gie` is 1. At machine privilege it is never eligible.
- R5: When at least one source is eligible, `take_vld` is 1 and `take_cause` is the index of the lowest-numbered eligible source. Bit 0 has the highest priority.
- R6: When no source is eligible, `take_vld` is 0 and `take_cause` is 0.
- R7: The privilege is encoded U=0, S=1, M=3. The reserved value 2 behaves exactly like U=0.
- R8: The outputs are registered. A result reflects the inputs sampled at the previous rising edge, and it holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| irq_pend | input | 16 | Raised interrupt sources |
| irq_enab | input | 16 | Per-source enables |
| irq_dlg | input | 16 | Per-source delegation to supervisor level |
| cur_lvl | input | 2 | Current privilege (0=U, 1=S, 2 reserved as U, 3=M) |
| m_gie | input | 1 | Machine-level global interrupt enable |
| s_gie | input | 1 | Supervisor-level global interrupt enable |
| take_vld | output | 1 | An interrupt should be taken |
| take_cause | output | 4 | Index of the interrupt to take |

## Verification
Several properties are checked on every cycle against registered copies of the inputs:
- A chosen cause is both raised and enabled.
- No eligible bit lies below the chosen cause.
- A delegated cause is never chosen at machine privilege.
- A delegated cause at supervisor privilege requires `s_gie`.
- An empty eligible vector gives no output.

Only the bench scenarios can show that an invalid result carries cause 0. Only they can show that the reserved privilege behaves like user level, or that the result appears one edge late and holds in between. These checks compare the outputs against a reference model over directed and random patterns.

// File: rtl/intr_arbiter_pkg.sv
package intr_arbiter_pkg;

  typedef enum logic [1:0] {
    LVL_USR = 2'd0,
    LVL_SUP = 2'd1,
    LVL_RSV = 2'd2,
    LVL_MCH = 2'd3
  } lvl_e;

  // Reserved encoding folds onto user level.
  function automatic lvl_e lvl_norm(input logic [1:0] raw);
    lvl_e v;
    v = lvl_e'(raw);
    if (v == LVL_RSV) v = LVL_USR;
    return v;
  endfunction

  // Machine-level sources: open below M, or at M with its global bit.
  function automatic logic mach_open(input lvl_e lvl, input logic gie);
    return (lvl != LVL_MCH) || gie;
  endfunction

  // Supervisor-level sources: open at U, or at S with its global bit.
  function automatic logic sup_open(input lvl_e lvl, input logic gie);
    return (lvl == LVL_USR) || ((lvl == LVL_SUP) && gie);
  endfunction

endpackage

// File: rtl/intr_lvl_gate.sv
module intr_lvl_gate
  import intr_arbiter_pkg::*;
(
  input  logic [1:0] lvl_raw,
  input  logic       m_gie,
  input  logic       s_gie,
  output logic       m_open,
  output logic       s_open
);
  lvl_e lvl;

  always_comb begin
    lvl    = lvl_norm(lvl_raw);
    m_open = mach_open(lvl, m_gie);
    s_open = sup_open(lvl, s_gie);
  end
endmodule

// File: rtl/intr_elig_mask.sv
module intr_elig_mask #(
  parameter int N = 16
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] enab,
  input  logic [N-1:0] dlg,
  input  logic         m_open,
  input  logic         s_open,
  output logic [N-1:0] elig
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic cand;
      logic lvl_ok;
      assign cand    = pend[i] & enab[i];
      assign lvl_ok  = dlg[i] ? s_open : m_open;
      assign elig[i] = cand & lvl_ok;
    end
  endgenerate
endmodule

// File: rtl/intr_low_find.sv
module intr_low_find #(
  parameter int N  = 16,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [CW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign first[i]  = vec[i] & ~seen[i];
      assign seen[i+1] = seen[i] | vec[i];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (first[k]) idx = idx | CW'(k);
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
  parameter int N  = 16,
  parameter int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          srst,
  input  logic [N-1:0]  irq_pend,
  input  logic [N-1:0]  irq_enab,
  input  logic [N-1:0]  irq_dlg,
  input  logic [1:0]    cur_lvl,
  input  logic          m_gie,
  input  logic          s_gie,
  output logic          take_vld,
  output logic [CW-1:0] take_cause
);
  logic          m_open;
  logic          s_open;
  logic [N-1:0]  elig_w;
  logic          pick_any;
  logic [CW-1:0] pick_idx;

  intr_lvl_gate u_gate (
    .lvl_raw (cur_lvl),
    .m_gie   (m_gie),
    .s_gie   (s_gie),
    .m_open  (m_open),
    .s_open  (s_open)
  );

  intr_elig_mask #(.N(N)) u_mask (
    .pend   (irq_pend),
    .enab   (irq_enab),
    .dlg    (irq_dlg),
    .m_open (m_open),
    .s_open (s_open),
    .elig   (elig_w)
  );

  intr_low_find #(.N(N), .CW(CW)) u_find (
    .vec (elig_w),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      take_vld   <= 1'b0;
      take_cause <= '0;
    end else begin
      take_vld   <= pick_any;
      take_cause <= pick_any ? pick_idx : '0;
    end
  end
endmodule

// File: rtl/intr_arbiter_chk.sv
module intr_arbiter_chk #(
  parameter int N  = 16,
  parameter int CW = $clog2(N)
) (
  input logic          clk,
  input logic          srst,
  input logic [N-1:0]  irq_pend,
  input logic [N-1:0]  irq_enab,
  input logic [N-1:0]  irq_dlg,
  input logic [1:0]    cur_lvl,
  input logic          s_gie,
  input logic [N-1:0]  elig_w,
  input logic          take_vld,
  input logic [CW-1:0] take_cause
);
  logic [N-1:0] pend_q, enab_q, dlg_q, elig_q;
  logic [1:0]   lvl_q;
  logic         sgie_q;
  logic [N-1:0] below;

  always_ff @(posedge clk) begin
    pend_q <= irq_pend;
    enab_q <= irq_enab;
    dlg_q  <= irq_dlg;
    elig_q <= elig_w;
    lvl_q  <= cur_lvl;
    sgie_q <= s_gie;
  end

  always_comb below = (N'(1) << take_cause) - N'(1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    srst |=> (!take_vld && take_cause == '0));

  // R2
  cand_source_chk: assert property (@(posedge clk) disable iff (srst)
    take_vld |-> (pend_q[take_cause] && enab_q[take_cause]));

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (srst)
    take_vld |-> (elig_q[take_cause] && (elig_q & below) == '0));

  // R4
  no_dlg_at_m_chk: assert property (@(posedge clk) disable iff (srst)
    (take_vld && lvl_q == 2'd3) |-> !dlg_q[take_cause]);

  // R4
  dlg_at_s_gie_chk: assert property (@(posedge clk) disable iff (srst)
    (take_vld && lvl_q == 2'd1 && dlg_q[take_cause]) |-> sgie_q);

  // R6
  empty_idle_chk: assert property (@(posedge clk) disable iff (srst)
    (elig_w == '0) |=> !take_vld);
endmodule

bind intr_arbiter intr_arbiter_chk #(.N(N), .CW(CW)) u_chk (
  .clk        (clk),
  .srst       (srst),
  .irq_pend   (irq_pend),
  .irq_enab   (irq_enab),
  .irq_dlg    (irq_dlg),
  .cur_lvl    (cur_lvl),
  .s_gie      (s_gie),
  .elig_w     (elig_w),
  .take_vld   (take_vld),
  .take_cause (take_cause)
);

// File: tb/sim_intr_arbiter.sv
`timescale 1ns/100ps
module sim_intr_arbiter;
  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic [15:0] irq_pend = '0, irq_enab = '0, irq_dlg = '0;
  logic [1:0]  cur_lvl = 2'd0;
  logic        m_gie = 1'b0, s_gie = 1'b0;
  logic        take_vld;
  logic [3:0]  take_cause;

  int vectors = 0;
  int miscmp  = 0;
  bit prev_v = 1'b0;
  int prev_c = 0;

  always #2.5 clk = ~clk;

  intr_arbiter u0 (
    .clk(clk), .srst(srst), .irq_pend(irq_pend), .irq_enab(irq_enab),
    .irq_dlg(irq_dlg), .cur_lvl(cur_lvl), .m_gie(m_gie), .s_gie(s_gie),
    .take_vld(take_vld), .take_cause(take_cause)
  );

  // Behavioural reference: walk sources from 0 upward.
  task automatic model(input logic [15:0] p, input logic [15:0] e,
                       input logic [15:0] d, input int lvl, input bit mg,
                       input bit sg, output bit v, output int c);
    int eff;
    v = 0; c = 0;
    eff = (lvl == 2) ? 0 : lvl;
    for (int i = 0; i < 16; i++) begin
      bit ok;
      if (!(p[i] && e[i])) continue;
      if (d[i]) ok = (eff == 0) || (eff == 1 && sg);
      else      ok = (eff != 3) || mg;
      if (ok) begin v = 1; c = i; break; end
    end
  endtask

  task automatic cmp(input string tag, input bit ev, input int ec);
    vectors++;
    if (take_vld !== ev || int'(take_cause) !== ec) begin
      miscmp++;
      $display("FAIL %s: got vld=%0b cause=%0d, expected vld=%0b cause=%0d",
               tag, take_vld, take_cause, ev, ec);
    end
  endtask

  // Drive at a falling edge, confirm hold, then check one edge later.
  task automatic apply(input string tag, input logic [15:0] p,
                       input logic [15:0] e, input logic [15:0] d,
                       input int lvl, input bit mg, input bit sg);
    bit ev; int ec;
    irq_pend = p; irq_enab = e; irq_dlg = d;
    cur_lvl = lvl[1:0]; m_gie = mg; s_gie = sg;
    #1;
    cmp("R8 hold", prev_v, prev_c);
    @(posedge clk); @(negedge clk);
    model(p, e, d, lvl, mg, sg, ev, ec);
    cmp(tag, ev, ec);
    prev_v = ev; prev_c = ec;
  endtask

  initial begin
    #1_000_000;
    miscmp++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    irq_pend = 16'hFFFF; irq_enab = 16'hFFFF; m_gie = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset", 0, 0);
    srst = 1'b0;

    apply("R2 disabled", 16'h0010, 16'h0000, 16'h0000, 0, 1, 1);
    apply("R2 masked",   16'h00F0, 16'h0040, 16'h0000, 0, 1, 1);
    apply("R3 M at U",   16'h0080, 16'hFFFF, 16'h0000, 0, 0, 0);
    apply("R3 M at S",   16'h0080, 16'hFFFF, 16'h0000, 1, 0, 0);
    apply("R3 M at M off", 16'h0080, 16'hFFFF, 16'h0000, 3, 0, 1);
    apply("R3 M at M on",  16'h0080, 16'hFFFF, 16'h0000, 3, 1, 0);
    apply("R4 S at U",   16'h0020, 16'hFFFF, 16'h0020, 0, 0, 0);
    apply("R4 S at S off", 16'h0020, 16'hFFFF, 16'h0020, 1, 1, 0);
    apply("R4 S at S on",  16'h0020, 16'hFFFF, 16'h0020, 1, 0, 1);
    apply("R4 S at M",   16'h0020, 16'hFFFF, 16'h0020, 3, 1, 1);
    apply("R4 mix at M", 16'h0022, 16'hFFFF, 16'h0002, 3, 1, 1);
    apply("R7 rsv S",    16'h0200, 16'hFFFF, 16'h0200, 2, 0, 0);
    apply("R7 rsv M",    16'h0400, 16'hFFFF, 16'h0000, 2, 0, 0);
    apply("R5 low wins", 16'hA508, 16'hFFFF, 16'h0000, 3, 1, 0);
    apply("R5 bit0",     16'hFFFF, 16'hFFFF, 16'h0000, 0, 0, 0);
    apply("R5 bit15",    16'h8000, 16'hFFFF, 16'h0000, 0, 0, 0);
    apply("R5 skip dlg", 16'h1003, 16'hFFFF, 16'h0003, 1, 1, 0);
    apply("R6 none",     16'h0000, 16'hFFFF, 16'h0000, 0, 1, 1);

    for (int n = 0; n < 300; n++) begin
      apply("R5 random", 16'($urandom), 16'($urandom), 16'($urandom),
            int'($urandom_range(0, 3)), bit'($urandom), bit'($urandom));
    end

    irq_pend = 16'h0001; irq_enab = 16'h0001;
    srst = 1'b1;
    @(posedge clk); @(negedge clk);
    cmp("R1 reset again", 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule